// File: doc/BRIEF.md
# Qualified ROM Bank Select Register

This block lets a CPU choose which of six 4 MiB data-ROM banks is seen through a fixed 4 MiB read window in its address space. Software writes a 16-bit word to a two-word I/O slot. The bank changes only when three conditions hold together: the write lands on the second word of the slot, an enable bit is set in the data, and the four-bit code at the top of the word falls inside a narrow accepted range. Any write that fails one of these conditions leaves the current bank in place.

A combinational window decoder sits alongside the register. It flags addresses that fall inside the window. For those addresses it builds the physical ROM offset by placing the bank index above the low 22 address bits. A read in the same cycle as an accepted write still sees the old bank. The new bank applies from the next clock edge.

Top module: `qualBankSel`

## Requirements
- R1: A write with `wrOffset` = 0 never changes `bankIdx`. Without a write (`wrEn` low), `bankIdx` also holds.
- R2: A write with `wrOffset` = 1 changes the bank only when data bit 11 is 1.
- R3: With `wrOffset` = 1 and bit 11 set, a code in bits 15:12 of 0x8 to 0xD is accepted. The new `bankIdx` is the code's low three bits, giving 0 to 5.
- R4: With `wrOffset` = 1 and bit 11 set, a code of 0x0 to 0x7, 0xE or 0xF leaves `bankIdx` at its previous value.
- R5: `bankIdx` takes its new value at the clock edge that samples the accepted write. Before that edge, `physAddr` is still formed from the old bank.
- R6: After reset, `bankIdx` is 0.
- R7: `winHit` is 1 exactly for `rdAddr` in 0x8000_0000 to 0x803F_FFFF inclusive.
- R8: When `winHit` is 1, `physAddr` equals `bankIdx` × 0x400000 + `rdAddr`[21:0]. The low 22 bits pass through unchanged.
- R9: `bankIdx` never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | I/O write strobe for the register slot |
| wrOffset | input | 1 | Word offset within the two-word slot |
| wrData | input | 16 | Written data word |
| rdAddr | input | 32 | CPU read address |
| bankIdx | output | 3 | Current bank index |
| winHit | output | 1 | High when `rdAddr` lies inside the banked window |
| physAddr | output | 25 | Physical ROM byte offset |

## Verification
A wrong stored bank appears at once on `bankIdx`. On the next read inside the window, it also appears in the top three bits of `physAddr`, so every window access made after the bad write reveals it. A qualification fault shows up in the cycle after the offending write, as a `bankIdx` that moved when it should have held, or held when it should have moved. The bench checks this after every write of an exhaustive sweep over offset, enable and code, starting from each of the six banks. It also probes the addresses on both sides of each window edge.

// File: rtl/bankSelPkg.sv
package bankSelPkg;
  localparam int BANK_W = 3;

  // Strobe from control to datapath: load request plus the decoded index.
  typedef struct packed {
    logic              load;
    logic [BANK_W-1:0] idx;
  } bankStrobe_t;
endpackage

// File: rtl/bankSelCtrl.sv
module bankSelCtrl
  import bankSelPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int EN_BIT   = 11,
  parameter int CODE_MSB = 15,
  parameter int CODE_W   = 4,
  parameter int CODE_LO  = 8,
  parameter int CODE_HI  = 13
) (
  input  logic              wrEn,
  input  logic              wrOffset,
  input  logic [DATA_W-1:0] wrData,
  output bankStrobe_t       strobe
);
  logic [CODE_W-1:0] code;
  logic              codeOk;
  logic              slotOk;

  assign code   = wrData[CODE_MSB -: CODE_W];
  assign codeOk = (int'(code) >= CODE_LO) && (int'(code) <= CODE_HI);
  // Only the second word of the slot carries the bank control.
  assign slotOk = wrEn && wrOffset;

  always_comb begin
    strobe.load = slotOk && wrData[EN_BIT] && codeOk;
    strobe.idx  = code[BANK_W-1:0];
  end
endmodule

// File: rtl/bankSelPath.sv
module bankSelPath
  import bankSelPkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_LOG2 = 22,
  parameter logic [31:0] WIN_BASE = 32'h8000_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  bankStrobe_t                strobe,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic [BANK_W-1:0]          bankIdx,
  output logic                       winHit,
  output logic [BANK_W+WIN_LOG2-1:0] physAddr
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  logic [BANK_W-1:0] bankQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bankQ <= '0;
    else if (strobe.load) bankQ <= strobe.idx;
  end

  assign bankIdx  = bankQ;
  assign winHit   = (rdAddr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
  assign physAddr = {bankQ, rdAddr[WIN_LOG2-1:0]};
endmodule

// File: rtl/qualBankSel.sv
module qualBankSel
  import bankSelPkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 32,
  parameter int          WIN_LOG2 = 22,
  parameter logic [31:0] WIN_BASE = 32'h8000_0000,
  parameter int          EN_BIT   = 11,
  parameter int          CODE_LO  = 8,
  parameter int          CODE_HI  = 13,
  localparam int         PHYS_W   = BANK_W + WIN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrOffset,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BANK_W-1:0] bankIdx,
  output logic              winHit,
  output logic [PHYS_W-1:0] physAddr
);
  bankStrobe_t strobe;

  bankSelCtrl #(
    .DATA_W(DATA_W), .EN_BIT(EN_BIT), .CODE_MSB(DATA_W-1), .CODE_W(4),
    .CODE_LO(CODE_LO), .CODE_HI(CODE_HI)
  ) u_ctrl (
    .wrEn(wrEn), .wrOffset(wrOffset), .wrData(wrData), .strobe(strobe)
  );

  bankSelPath #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .WIN_BASE(WIN_BASE)
  ) u_path (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdAddr(rdAddr),
    .bankIdx(bankIdx), .winHit(winHit), .physAddr(physAddr)
  );
endmodule

// File: rtl/qualBankSelChk.sv
module qualBankSelChk (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic        wrOffset,
  input logic [15:0] wrData,
  input logic [31:0] rdAddr,
  input logic [2:0]  bankIdx,
  input logic        winHit,
  input logic [24:0] physAddr
);
  logic [3:0] code;
  logic       inRange;
  assign code    = wrData[15:12];
  assign inRange = (code >= 4'h8) && (code <= 4'hD);

  a_r1_offset0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrOffset) |=> $stable(bankIdx));
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(bankIdx));
  a_r2_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrData[11]) |=> $stable(bankIdx));
  a_r3_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrOffset && wrData[11] && inRange) |=> (bankIdx == $past(wrData[14:12])));
  a_r4_badcode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrOffset && wrData[11] && !inRange) |=> $stable(bankIdx));
  a_r7_window: assert property (@(posedge clk) disable iff (!rst_n)
    winHit == ((rdAddr >= 32'h8000_0000) && (rdAddr <= 32'h803F_FFFF)));
  a_r8_phys: assert property (@(posedge clk) disable iff (!rst_n)
    winHit |-> (physAddr == 25'(bankIdx) * 25'h40_0000 + 25'(rdAddr & 32'h3F_FFFF)));
  a_r9_bank_max: assert property (@(posedge clk) disable iff (!rst_n)
    bankIdx <= 3'd5);
endmodule

bind qualBankSel qualBankSelChk u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrOffset(wrOffset), .wrData(wrData),
  .rdAddr(rdAddr), .bankIdx(bankIdx), .winHit(winHit), .physAddr(physAddr)
);

// File: tb/tb_qualBankSel.sv
module tb_qualBankSel;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wrEn = 0;
  logic        wrOffset = 0;
  logic [15:0] wrData = '0;
  logic [31:0] rdAddr = '0;
  logic [2:0]  bankIdx;
  logic        winHit;
  logic [24:0] physAddr;

  int errors = 0;
  int checks = 0;
  int expBank = 0;

  always #5 clk = ~clk;

  qualBankSel dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrOffset(wrOffset), .wrData(wrData),
    .rdAddr(rdAddr), .bankIdx(bankIdx), .winHit(winHit), .physAddr(physAddr)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drive a one-cycle write; returns at the negedge after the sampling edge.
  task automatic doWrite(input logic off, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1; wrOffset = off; wrData = d;
    @(negedge clk);
    wrEn = 0; wrOffset = 0; wrData = '0;
  endtask

  // Bench model of the register update rules.
  function automatic int nextBank(input int cur, input logic off, input logic [15:0] d);
    int c;
    c = int'(d[15:12]);
    if (off && d[11] && c >= 8 && c <= 13) return c - 8;
    return cur;
  endfunction

  task automatic probe(input logic [31:0] a, input string tag);
    longint expHit;
    rdAddr = a;
    #1;
    expHit = (a >= 32'h8000_0000 && a < 32'h8040_0000) ? 1 : 0;
    check({"R7 ", tag}, winHit, expHit);
    if (expHit == 1)
      check({"R8 ", tag}, physAddr, longint'(expBank) * 64'h40_0000 + longint'(a - 32'h8000_0000));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset bank", bankIdx, 0);
    rst_n = 1;
    @(negedge clk);
    check("R6 bank after reset release", bankIdx, 0);
    check("R1 idle hold", bankIdx, 0);

    // Exhaustive sweep: every starting bank, offset, enable bit and code.
    for (int pre = 0; pre < 6; pre++) begin
      for (int off = 0; off < 2; off++) begin
        for (int en = 0; en < 2; en++) begin
          for (int c = 0; c < 16; c++) begin
            logic [15:0] d;
            doWrite(1'b1, 16'(((pre + 8) << 12) | 16'h0800));
            expBank = pre;
            d = 16'((c << 12) | (en << 11) | 16'h0155);
            doWrite(off[0], d);
            expBank = nextBank(expBank, off[0], d);
            if (!off[0])          check("R1 offset zero", bankIdx, expBank);
            else if (en == 0)     check("R2 enable clear", bankIdx, expBank);
            else if (c >= 8 && c <= 13) check("R3 accepted code", bankIdx, expBank);
            else                  check("R4 rejected code", bankIdx, expBank);
            check("R9 bank max", bankIdx <= 5, 1);
          end
        end
      end
    end

    // Window edges and pass-through for every bank.
    for (int b = 0; b < 6; b++) begin
      doWrite(1'b1, 16'(((b + 8) << 12) | 16'h0800));
      expBank = b;
      probe(32'h8000_0000, "base");
      probe(32'h803F_FFFF, "top");
      probe(32'h8012_3456, "mid");
      probe(32'h7FFF_FFFF, "below");
      probe(32'h8040_0000, "above");
      probe(32'h0000_0000, "zero");
      probe(32'hFFFF_FFFF, "ones");
    end

    // R5: same-cycle read uses the old bank, next edge the new one.
    doWrite(1'b1, 16'hA800);
    expBank = 2;
    @(negedge clk);
    rdAddr = 32'h8000_0010;
    wrEn = 1; wrOffset = 1; wrData = 16'hD800;
    #1;
    check("R5 old bank before edge", physAddr, 64'h2 * 64'h40_0000 + 64'h10);
    @(negedge clk);
    wrEn = 0; wrOffset = 0; wrData = '0;
    expBank = 5;
    check("R5 new bank after edge", bankIdx, 5);
    check("R5 new phys after edge", physAddr, 64'h5 * 64'h40_0000 + 64'h10);

    // R1: many idle cycles keep the bank.
    repeat (5) @(negedge clk);
    check("R1 idle long hold", bankIdx, 5);

    // R6: reset in mid-run returns to bank 0.
    rst_n = 0;
    #1;
    check("R6 async reset", bankIdx, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R6 held zero", bankIdx, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule